// File: doc/BRIEF.md
# Ethernet PHY Strap Capture and MII Isolation Controller

This block sits beside the MII pad ring of an Ethernet transceiver. Five receive-side pins double as configuration inputs: the four receive-data pins and the collision pin. During hardware reset their drivers are switched off and the block samples them. The value present on the last reset cycle becomes the 5-bit station address. A board may leave any strap resistor unfitted. An unfitted bit then takes its internal pull level: bit 0 pulls high and bits 4:1 pull low.

After reset the address sits in a management register. The block answers a management access only when the access's target address equals that register. The block also decides whether the MII receive pins and both clock pins are driven or left floating. When isolated it blocks the transmit data and enable path. Isolation has two sources. One is a flag set by strapping address zero. The other is the isolate bit of the mode-control register. A management write of zero into the address field does not isolate the block.

A simple parallel register port stands in for the serial management interface. A low output enable means the pad ring presents high impedance on that pin.

Top module: `phy_strap_ctrl`

## Requirements
- R1: While `rst` is high, `pad_oe` is low, and `gated_txd`/`gated_tx_en` are zero from the clock edge after reset is first seen.
- R2: The address field equals the effective strap value on the last clock edge with `rst` high. `strap_in[0]` (RXD_0 pin) maps to address bit 0, `strap_in[3:1]` map to bits 3:1, and `strap_in[4]` (COL pin) maps to bit 4. The field is readable at register 19h, bits [4:0], with bits [15:5] reading 0.
- R3: A strap bit whose `strap_fit` bit is 0 takes its pull value: bit 0 reads 1 and bits 4:1 read 0. With no straps fitted the address is 01h.
- R4: A strap value of 00000 puts the block in isolate mode when reset ends. Register 00h bit 10 then reads 1.
- R5: A management write to register 19h changes only the address field. Writing 0 there leaves isolate mode unchanged.
- R6: Writing register 00h with bit 10 set enters isolate mode. Writing it with bit 10 clear leaves isolate mode, including isolation caused by a zero strap.
- R7: In isolate mode `pad_oe` is low and `gated_txd`/`gated_tx_en` are zero. Both take effect one cycle after the isolate state changes.
- R8: Management reads and writes work the same in isolate mode as outside it.
- R9: An access whose `mg_phy` differs from the address field has no effect: no read response and no register change.
- R10: Out of reset and not isolated, `pad_oe` is high. Registered pad outputs and the transmit path follow their inputs with one cycle of latency.
- R11: An accepted read returns `mg_rvalid` high with `mg_rdata` on the cycle after the request. Unmapped register offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| strap_in | input | 5 | Pad input levels of the shared pins (bit 0 RXD_0 ... bit 4 COL) |
| strap_fit | input | 5 | 1 = external strap resistor fitted on that pin |
| core_rxd | input | 4 | Receive data from the PHY core |
| core_col | input | 1 | Collision from the PHY core |
| core_rx_dv | input | 1 | Receive data valid from the core |
| core_rx_er | input | 1 | Receive error from the core |
| core_crs | input | 1 | Carrier sense from the core |
| core_rx_clk | input | 1 | Receive clock from the core |
| core_tx_clk | input | 1 | Transmit clock from the core |
| pad_rxd | output | 4 | Registered receive data to pads |
| pad_col | output | 1 | Registered collision to pad |
| pad_rx_dv | output | 1 | Registered receive valid to pad |
| pad_rx_er | output | 1 | Registered receive error to pad |
| pad_crs | output | 1 | Registered carrier sense to pad |
| pad_rx_clk | output | 1 | Receive clock to pad |
| pad_tx_clk | output | 1 | Transmit clock to pad |
| pad_oe | output | 1 | Output enable for all MII output pads (0 = high impedance) |
| mii_txd | input | 4 | Transmit data from the MAC |
| mii_tx_en | input | 1 | Transmit enable from the MAC |
| gated_txd | output | 4 | Transmit data to the core, zero when isolated |
| gated_tx_en | output | 1 | Transmit enable to the core, zero when isolated |
| mg_valid | input | 1 | Management access request |
| mg_write | input | 1 | 1 = write, 0 = read |
| mg_phy | input | 5 | Target station address of the access |
| mg_reg | input | 5 | Register offset |
| mg_wdata | input | 16 | Write data |
| mg_rdata | output | 16 | Read data |
| mg_rvalid | output | 1 | Read data valid |

## Verification
Two internal faults matter most: a wrong latched address and a stuck isolate state. A wrong latched address shows on the cycle after reset as silence to reads at the expected address. A stuck or lost isolate state shows at the pads one cycle after the event that should have changed it: `pad_oe` has the wrong level and the transmit path is either blocked or open when it should not be. The bench uses a read scoreboard, so a dropped, extra or wrong register response surfaces on the cycle after the request. Strap patterns cover an all-unfitted board, a mixed pattern that tells every bit position apart, and the all-zero strap.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int RXD_W   = 4;
  localparam int ISO_BIT = 10;
  localparam logic [ADDR_W-1:0] REG_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] REG_CFG  = 5'h19;
  localparam logic [ADDR_W-1:0] PULL_LEVEL = 5'b00001;

  typedef struct packed {
    logic             valid;
    logic             write;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regsel;
    logic [DATA_W-1:0] wdata;
  } mg_req_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int W = ADDR_W,
  parameter logic [W-1:0] PULL = PULL_LEVEL
) (
  input  logic [W-1:0] strap_in,
  input  logic [W-1:0] strap_fit,
  output logic [W-1:0] strap_eff,
  output logic         strap_zero
);
  // Each bit picks the board strap when fitted, else its internal pull.
  for (genvar b = 0; b < W; b++) begin : g_bit
    assign strap_eff[b] = strap_fit[b] ? strap_in[b] : PULL[b];
  end
  assign strap_zero = (strap_eff == '0);
endmodule

// File: rtl/mgmt_regs.sv
module mgmt_regs
  import strap_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int IB = ISO_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] strap_eff,
  input  logic          strap_zero,
  input  mg_req_t       req,
  output logic [AW-1:0] phy_addr,
  output logic          iso,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          iso_strap;
  logic          iso_mode;
  logic          hit;
  logic [DW-1:0] rd_mux;

  assign hit = req.valid && (req.phy == phy_addr);
  assign iso = iso_strap | iso_mode;

  always_comb begin
    rd_mux = '0;
    case (req.regsel)
      REG_MODE: rd_mux[IB] = iso;
      REG_CFG:  rd_mux = {{(DW-AW){1'b0}}, phy_addr};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phy_addr  <= strap_eff;
      iso_strap <= strap_zero;
      iso_mode  <= 1'b0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= 1'b0;
      if (hit && req.write) begin
        case (req.regsel)
          REG_MODE: begin
            iso_mode <= req.wdata[IB];
            if (!req.wdata[IB]) iso_strap <= 1'b0;
          end
          REG_CFG: phy_addr <= req.wdata[AW-1:0];
          default: ;
        endcase
      end else if (hit) begin
        rvalid <= 1'b1;
        rdata  <= rd_mux;
      end
    end
  end
endmodule

// File: rtl/pad_gate.sv
module pad_gate
  import strap_pkg::*;
#(
  parameter int SW = ADDR_W,
  parameter int TW = RXD_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iso,
  input  logic [SW-1:0] core_shared,
  input  logic [2:0]    core_misc,
  input  logic [TW-1:0] tx_data,
  input  logic          tx_en,
  output logic [SW-1:0] pad_shared,
  output logic [2:0]    pad_misc,
  output logic          oe,
  output logic [TW-1:0] tx_data_q,
  output logic          tx_en_q
);
  for (genvar i = 0; i < SW; i++) begin : g_shared
    always_ff @(posedge clk) begin
      if (rst) pad_shared[i] <= 1'b0;
      else     pad_shared[i] <= core_shared[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_misc  <= '0;
      oe        <= 1'b0;
      tx_data_q <= '0;
      tx_en_q   <= 1'b0;
    end else begin
      pad_misc  <= core_misc;
      oe        <= !iso;
      tx_data_q <= iso ? '0 : tx_data;
      tx_en_q   <= tx_en && !iso;
    end
  end
endmodule

// File: rtl/phy_strap_ctrl.sv
module phy_strap_ctrl
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] strap_in,
  input  logic [ADDR_W-1:0] strap_fit,
  input  logic [RXD_W-1:0]  core_rxd,
  input  logic              core_col,
  input  logic              core_rx_dv,
  input  logic              core_rx_er,
  input  logic              core_crs,
  input  logic              core_rx_clk,
  input  logic              core_tx_clk,
  output logic [RXD_W-1:0]  pad_rxd,
  output logic              pad_col,
  output logic              pad_rx_dv,
  output logic              pad_rx_er,
  output logic              pad_crs,
  output logic              pad_rx_clk,
  output logic              pad_tx_clk,
  output logic              pad_oe,
  input  logic [RXD_W-1:0]  mii_txd,
  input  logic              mii_tx_en,
  output logic [RXD_W-1:0]  gated_txd,
  output logic              gated_tx_en,
  input  logic              mg_valid,
  input  logic              mg_write,
  input  logic [ADDR_W-1:0] mg_phy,
  input  logic [ADDR_W-1:0] mg_reg,
  input  logic [DATA_W-1:0] mg_wdata,
  output logic [DATA_W-1:0] mg_rdata,
  output logic              mg_rvalid
);
  logic [ADDR_W-1:0] strap_eff;
  logic              strap_zero;
  logic [ADDR_W-1:0] phy_addr;
  logic              iso;
  mg_req_t           req;
  logic [ADDR_W-1:0] shared_q;
  logic [2:0]        misc_q;

  assign req = '{valid: mg_valid, write: mg_write, phy: mg_phy,
                 regsel: mg_reg, wdata: mg_wdata};

  strap_capture u_cap (
    .strap_in  (strap_in),
    .strap_fit (strap_fit),
    .strap_eff (strap_eff),
    .strap_zero(strap_zero)
  );

  mgmt_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .strap_eff (strap_eff),
    .strap_zero(strap_zero),
    .req       (req),
    .phy_addr  (phy_addr),
    .iso       (iso),
    .rdata     (mg_rdata),
    .rvalid    (mg_rvalid)
  );

  pad_gate u_pads (
    .clk        (clk),
    .rst        (rst),
    .iso        (iso),
    .core_shared({core_col, core_rxd}),
    .core_misc  ({core_crs, core_rx_er, core_rx_dv}),
    .tx_data    (mii_txd),
    .tx_en      (mii_tx_en),
    .pad_shared (shared_q),
    .pad_misc   (misc_q),
    .oe         (pad_oe),
    .tx_data_q  (gated_txd),
    .tx_en_q    (gated_tx_en)
  );

  assign pad_rxd    = shared_q[RXD_W-1:0];
  assign pad_col    = shared_q[ADDR_W-1];
  assign pad_rx_dv  = misc_q[0];
  assign pad_rx_er  = misc_q[1];
  assign pad_crs    = misc_q[2];
  // Clocks are not retimed; the common enable floats them when isolated.
  assign pad_rx_clk = core_rx_clk;
  assign pad_tx_clk = core_tx_clk;
endmodule

// File: rtl/strap_ctrl_chk.sv
module strap_ctrl_chk
  import strap_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              iso,
  input logic [ADDR_W-1:0] strap_eff,
  input logic [ADDR_W-1:0] phy_addr,
  input logic              pad_oe,
  input logic [RXD_W-1:0]  gated_txd,
  input logic              gated_tx_en,
  input logic              mg_valid,
  input logic              mg_write,
  input logic [ADDR_W-1:0] mg_phy,
  input logic [ADDR_W-1:0] mg_reg,
  input logic              mg_rvalid
);
  a_r1_no_drive_in_reset: assert property (@(posedge clk)
    rst |=> !pad_oe);

  a_r4_zero_strap_isolates: assert property (@(posedge clk)
    ($past(rst) && !rst && $past(strap_eff) == '0) |-> iso);

  a_r5_cfg_write_keeps_iso: assert property (@(posedge clk) disable iff (rst)
    (mg_valid && mg_write && mg_phy == phy_addr && mg_reg == REG_CFG) |=> $stable(iso));

  a_r7_gate_when_iso: assert property (@(posedge clk) disable iff (rst)
    iso |=> (!pad_oe && !gated_tx_en && gated_txd == '0));

  a_r10_drive_when_free: assert property (@(posedge clk) disable iff (rst)
    !iso |=> pad_oe);

  a_r9_miss_ignored: assert property (@(posedge clk) disable iff (rst)
    (mg_valid && mg_phy != phy_addr) |=> (!mg_rvalid && $stable(phy_addr) && $stable(iso)));

  a_r11_read_response: assert property (@(posedge clk) disable iff (rst)
    (mg_valid && !mg_write && mg_phy == phy_addr) |=> mg_rvalid);
endmodule

bind phy_strap_ctrl strap_ctrl_chk i_chk (
  .clk        (clk),
  .rst        (rst),
  .iso        (iso),
  .strap_eff  (strap_eff),
  .phy_addr   (phy_addr),
  .pad_oe     (pad_oe),
  .gated_txd  (gated_txd),
  .gated_tx_en(gated_tx_en),
  .mg_valid   (mg_valid),
  .mg_write   (mg_write),
  .mg_phy     (mg_phy),
  .mg_reg     (mg_reg),
  .mg_rvalid  (mg_rvalid)
);

// File: tb/test_phy_strap_ctrl.sv
module test_phy_strap_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  strap_in = '0, strap_fit = '0;
  logic [3:0]  core_rxd = '0;
  logic        core_col = 0, core_rx_dv = 0, core_rx_er = 0, core_crs = 0;
  logic        core_rx_clk = 0, core_tx_clk = 0;
  logic [3:0]  pad_rxd;
  logic        pad_col, pad_rx_dv, pad_rx_er, pad_crs, pad_rx_clk, pad_tx_clk, pad_oe;
  logic [3:0]  mii_txd = '0;
  logic        mii_tx_en = 0;
  logic [3:0]  gated_txd;
  logic        gated_tx_en;
  logic        mg_valid = 0, mg_write = 0;
  logic [4:0]  mg_phy = '0, mg_reg = '0;
  logic [15:0] mg_wdata = '0;
  logic [15:0] mg_rdata;
  logic        mg_rvalid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  phy_strap_ctrl i_phy_strap_ctrl (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every read response must match the oldest expectation.
  always @(negedge clk) begin
    if (!rst && mg_rvalid) begin
      if (exp_q.size() == 0) begin
        check(0, "R9 unexpected response", {16'h0, mg_rdata}, 32'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(mg_rdata == e, t, {16'h0, mg_rdata}, {16'h0, e});
      end
    end
  end

  task automatic do_reset(input logic [4:0] s, input logic [4:0] fit);
    @(negedge clk);
    rst = 1; strap_in = s; strap_fit = fit;
    repeat (3) @(negedge clk);
    check(pad_oe == 0, "R1 oe during reset", {31'h0, pad_oe}, 32'h0);
    check(gated_tx_en == 0, "R1 tx gated during reset", {31'h0, gated_tx_en}, 32'h0);
    rst = 0;
    strap_in = 5'h1f; strap_fit = 5'h1f; // straps move after release: must not matter
    @(negedge clk);
  endtask

  task automatic mg_rd(input logic [4:0] phy, input logic [4:0] r, input bit resp,
                       input logic [15:0] e, input string t);
    mg_valid = 1; mg_write = 0; mg_phy = phy; mg_reg = r;
    if (resp) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(negedge clk);
    mg_valid = 0;
    if (!resp) check(mg_rvalid == 0, t, {31'h0, mg_rvalid}, 32'h0);
  endtask

  task automatic mg_wr(input logic [4:0] phy, input logic [4:0] r, input logic [15:0] d);
    mg_valid = 1; mg_write = 1; mg_phy = phy; mg_reg = r; mg_wdata = d;
    @(negedge clk);
    mg_valid = 0; mg_write = 0;
    @(negedge clk); // isolate changes feed the pad registers one cycle later
  endtask

  initial begin
    // Board with no straps fitted: pulls give 01h.
    do_reset(5'h00, 5'h00);
    mg_rd(5'h01, 5'h19, 1, 16'h0001, "R3 unfitted straps read 01h");
    check(pad_oe == 1, "R10 oe after reset", {31'h0, pad_oe}, 32'h1);
    core_rxd = 4'hA; core_col = 1; core_crs = 1; mii_txd = 4'h5; mii_tx_en = 1;
    @(negedge clk);
    check({pad_col, pad_rxd} == 5'h1A, "R10 shared pins follow core", {27'h0, pad_col, pad_rxd}, 32'h1A);
    check(pad_crs == 1, "R10 crs follows core", {31'h0, pad_crs}, 32'h1);
    check({gated_tx_en, gated_txd} == 5'h15, "R10 tx path open", {27'h0, gated_tx_en, gated_txd}, 32'h15);
    mg_rd(5'h01, 5'h07, 1, 16'h0000, "R11 unmapped register reads 0");

    // Mixed strap: bit 0 from RXD_0, bit 4 from COL, bit 0 fitted low.
    do_reset(5'b10110, 5'h1f);
    mg_rd(5'h16, 5'h19, 1, 16'h0016, "R2 strap 10110 latched");
    mg_rd(5'h01, 5'h19, 0, 16'h0000, "R9 stale address ignored");
    mg_wr(5'h01, 5'h00, 16'h0400); // missed write, must not isolate
    check(pad_oe == 1, "R9 missed write had no effect", {31'h0, pad_oe}, 32'h1);
    mg_rd(5'h16, 5'h00, 1, 16'h0000, "R9 mode reg unchanged");
    mg_wr(5'h16, 5'h19, 16'h0000);
    check(pad_oe == 1, "R5 zero address write no isolate", {31'h0, pad_oe}, 32'h1);
    mg_rd(5'h00, 5'h00, 1, 16'h0000, "R5 mode bit clear");
    mg_rd(5'h00, 5'h19, 1, 16'h0000, "R9 new address answers");
    mg_wr(5'h00, 5'h00, 16'h0400);
    check(pad_oe == 0, "R6 mode bit isolates", {31'h0, pad_oe}, 32'h0);
    check({gated_tx_en, gated_txd} == 5'h00, "R7 tx gated", {27'h0, gated_tx_en, gated_txd}, 32'h0);
    mg_rd(5'h00, 5'h00, 1, 16'h0400, "R8 read while isolated");
    mg_wr(5'h00, 5'h19, 16'h0009);
    mg_rd(5'h09, 5'h19, 1, 16'h0009, "R8 write while isolated");
    mg_wr(5'h09, 5'h00, 16'h0000);
    check(pad_oe == 1, "R6 clearing mode bit releases", {31'h0, pad_oe}, 32'h1);

    // Zero strap isolates at reset.
    do_reset(5'h00, 5'h1f);
    check(pad_oe == 0, "R4 zero strap isolates", {31'h0, pad_oe}, 32'h0);
    check(gated_tx_en == 0, "R7 tx_en blocked", {31'h0, gated_tx_en}, 32'h0);
    mg_rd(5'h00, 5'h00, 1, 16'h0400, "R4 mode bit reads isolated");
    mg_wr(5'h00, 5'h19, 16'h0003);
    check(pad_oe == 0, "R5 address write keeps strap isolate", {31'h0, pad_oe}, 32'h0);
    mg_wr(5'h03, 5'h00, 16'h0000);
    check(pad_oe == 1, "R6 strap isolate cleared", {31'h0, pad_oe}, 32'h1);
    check({gated_tx_en, gated_txd} == 5'h15, "R7 tx reopened", {27'h0, gated_tx_en, gated_txd}, 32'h15);

    @(negedge clk);
    check(exp_q.size() == 0, "R11 missing read responses", exp_q.size(), 32'h0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule